// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block drives a two-channel, 10-bit analog-to-digital converter. The converter is controlled through three signals: an active-high power-down line, a one-hot channel-select bus, and a data-valid return that comes with a data bus. Software-style logic gives the controller a one-cycle start request and a mask of the channels to measure. The controller then runs a full session on its own:

- it lowers power-down;
- it waits a fixed wake-up time, counted in clock cycles;
- it selects each requested channel in ascending order and stores each result in its own capture register;
- it raises power-down again and pulses a done flag.

A conversion begins only when the select bus goes from all-zero to a nonzero value. For that reason the controller always clears the bus to zero between two channels. It also waits until data-valid has dropped, and then keeps the bus at zero for one further cycle, before it selects the next channel.

A watchdog guards every conversion. If data-valid does not arrive within a set number of cycles, the session is abandoned: the select bus is cleared, the converter is powered down and a sticky error flag is raised. The error flag is cleared by the next accepted start.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset and whenever idle, `adc_pd_o` is 1, `adc_sel_o` is 0, and `busy_o`, `done_o` and `err_o` are 0.
- R2: After an accepted start, `adc_pd_o` goes low and `adc_sel_o` stays 0 for exactly WAKE_CYC cycles before the first channel is selected.
- R3: `adc_sel_o` has at most one bit set, and it is nonzero only while `adc_pd_o` is 0. Bit i of `adc_sel_o` selects channel i.
- R4: When `adc_valid_i` is 1 while channel i is selected, `adc_data_i` is stored in `result_o[i*DATA_W +: DATA_W]`. The capture registers of other channels keep their values.
- R5: After the last requested result is stored, `done_o` is 1 for exactly one cycle, and in that cycle `adc_pd_o` is already 1.
- R6: Bit i of `ch_mask_i` requests channel i. The requested channels are converted in ascending index order, each exactly once per accepted start.
- R7: After a capture, `adc_sel_o` returns to 0. It never changes directly from one nonzero value to another. A new channel is selected only after a cycle in which `adc_sel_o` was 0 and `adc_valid_i` was 0.
- R8: If `adc_valid_i` does not arrive within TIMEOUT_CYC cycles of a channel being selected, the controller does the following:
  - `adc_sel_o` returns to 0 after exactly TIMEOUT_CYC cycles;
  - `adc_pd_o` returns to 1;
  - `err_o` becomes 1 and no done pulse is given;
  - `err_o` stays 1 until the next accepted start.
- R9: A start request that arrives while `busy_o` is 1 is ignored.
- R10: A start request with an all-zero mask is ignored: the controller stays idle and powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle session start request |
| ch_mask_i | input | NUM_CH | Channels to convert, sampled with start |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse when all results are stored |
| err_o | output | 1 | Sticky conversion-timeout flag |
| result_o | output | NUM_CH*DATA_W | Capture registers, channel i at bits i*DATA_W upward |
| adc_pd_o | output | 1 | Converter power-down, high = off |
| adc_sel_o | output | NUM_CH | One-hot channel select |
| adc_data_i | input | DATA_W | Converter result |
| adc_valid_i | input | 1 | Converter result valid |

## Verification
The bench builds the controller with WAKE_CYC=12 and TIMEOUT_CYC=20, in place of defaults sized for tens of microseconds. With these values it can count the wake-up window and the timeout window cycle by cycle and compare them with their exact lengths. The converter model answers 5 cycles after a select edge. This sits well inside the timeout, so normal sessions never trip it. A mute switch in the model removes the answer altogether, which makes the abort path reachable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAKE = 2'd1,
    SEQ_CONV = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_e;

  // Width needed to hold a down-counter preset of (n - 1), never less than 1.
  function automatic int count_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

  // Larger of two window lengths; the shared timer is sized for it.
  function automatic int max_window(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] preset_i,
  output logic          expired_o
);

  logic [TW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= preset_i;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired_o = (remain_q == '0);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 10,
  parameter int IW     = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en_i,
  input  logic [IW-1:0]            cap_idx_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] result_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              hit;

    assign hit = cap_en_i && (cap_idx_i == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (hit) begin
        slot_q <= data_i;
      end
    end

    assign result_o[g*DATA_W +: DATA_W] = slot_q;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int WAKE_CYC    = 3000,
  parameter int TIMEOUT_CYC = 4096,
  parameter int TW          = 12,
  parameter int IW          = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              valid_i,
  input  logic              tmr_exp_i,
  output logic              tmr_load_o,
  output logic [TW-1:0]     tmr_preset_o,
  output logic              cap_en_o,
  output logic [IW-1:0]     cap_idx_o,
  output logic [NUM_CH-1:0] sel_o,
  output logic              pd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam logic [TW-1:0] WAKE_PRESET = TW'(WAKE_CYC - 1);
  localparam logic [TW-1:0] CONV_PRESET = TW'(TIMEOUT_CYC - 1);

  // Lowest set bit of a mask, kept as a one-hot vector.
  function automatic logic [NUM_CH-1:0] lowest_bit(input logic [NUM_CH-1:0] m);
    return m & (~m + 1'b1);
  endfunction

  // Index of the lowest set bit of a mask.
  function automatic logic [IW-1:0] lowest_idx(input logic [NUM_CH-1:0] m);
    logic [IW-1:0] idx;
    idx = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (m[k]) idx = IW'(k);
    end
    return idx;
  endfunction

  seq_state_e        state_q, state_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic              err_q, err_d;
  logic              done_q, done_d;

  logic accept_w;
  logic wake_end_w;
  logic capture_w;
  logic abort_w;
  logic gap_clear_w;

  assign accept_w    = (state_q == SEQ_IDLE) && start_i && (mask_i != '0);
  assign wake_end_w  = (state_q == SEQ_WAKE) && tmr_exp_i;
  assign capture_w   = (state_q == SEQ_CONV) && valid_i;
  assign abort_w     = (state_q == SEQ_CONV) && !valid_i && tmr_exp_i;
  assign gap_clear_w = (state_q == SEQ_GAP) && !valid_i;

  always_comb begin
    state_d      = state_q;
    pend_d       = pend_q;
    err_d        = err_q;
    done_d       = 1'b0;
    tmr_load_o   = 1'b0;
    tmr_preset_o = CONV_PRESET;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept_w) begin
          state_d      = SEQ_WAKE;
          pend_d       = mask_i;
          err_d        = 1'b0;
          tmr_load_o   = 1'b1;
          tmr_preset_o = WAKE_PRESET;
        end
      end
      SEQ_WAKE: begin
        if (wake_end_w) begin
          state_d    = SEQ_CONV;
          tmr_load_o = 1'b1;
        end
      end
      SEQ_CONV: begin
        if (capture_w) begin
          state_d = SEQ_GAP;
          pend_d  = pend_q & ~lowest_bit(pend_q);
        end else if (abort_w) begin
          state_d = SEQ_IDLE;
          pend_d  = '0;
          err_d   = 1'b1;
        end
      end
      SEQ_GAP: begin
        if (gap_clear_w) begin
          if (pend_q == '0) begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d    = SEQ_CONV;
            tmr_load_o = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign cap_en_o  = capture_w;
  assign cap_idx_o = lowest_idx(pend_q);
  assign sel_o     = (state_q == SEQ_CONV) ? lowest_bit(pend_q) : '0;
  assign pd_o      = (state_q == SEQ_IDLE);
  assign busy_o    = (state_q != SEQ_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DATA_W      = 10,
  parameter int WAKE_CYC    = 3000,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NUM_CH-1:0]        ch_mask_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic [NUM_CH*DATA_W-1:0] result_o,
  output logic                     adc_pd_o,
  output logic [NUM_CH-1:0]        adc_sel_o,
  input  logic [DATA_W-1:0]        adc_data_i,
  input  logic                     adc_valid_i
);

  localparam int TW = count_width(max_window(WAKE_CYC, TIMEOUT_CYC));
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic          tmr_load_w;
  logic [TW-1:0] tmr_preset_w;
  logic          tmr_exp_w;
  logic          cap_en_w;
  logic [IW-1:0] cap_idx_w;

  adc_seq_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load_w),
    .preset_i  (tmr_preset_w),
    .expired_o (tmr_exp_w)
  );

  adc_seq_fsm #(
    .NUM_CH      (NUM_CH),
    .WAKE_CYC    (WAKE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .TW          (TW),
    .IW          (IW)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mask_i       (ch_mask_i),
    .valid_i      (adc_valid_i),
    .tmr_exp_i    (tmr_exp_w),
    .tmr_load_o   (tmr_load_w),
    .tmr_preset_o (tmr_preset_w),
    .cap_en_o     (cap_en_w),
    .cap_idx_o    (cap_idx_w),
    .sel_o        (adc_sel_o),
    .pd_o         (adc_pd_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  adc_seq_capture #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .IW     (IW)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en_i  (cap_en_w),
    .cap_idx_i (cap_idx_w),
    .data_i    (adc_data_i),
    .result_o  (result_o)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int NUM_CH   = 2,
  parameter int WAKE_CYC = 3000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic              err_o,
  input logic              busy_o,
  input logic              adc_pd_o,
  input logic [NUM_CH-1:0] adc_sel_o,
  input logic              adc_valid_i
);

  localparam int CW = $clog2(WAKE_CYC + 1) + 1;

  // Cycles of continuous power since the converter was last powered down.
  logic [CW-1:0] powered_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powered_cnt <= '0;
    end else if (adc_pd_o) begin
      powered_cnt <= '0;
    end else if (powered_cnt != CW'(WAKE_CYC)) begin
      powered_cnt <= powered_cnt + 1'b1;
    end
  end

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_sel_o));

  assert_sel_needs_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel_o != '0) |-> !adc_pd_o);

  assert_wake_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel_o != '0) |-> (powered_cnt == CW'(WAKE_CYC)));

  assert_no_hop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel_o != '0) |=> ((adc_sel_o == '0) || (adc_sel_o == $past(adc_sel_o))));

  assert_gap_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_valid_i) |-> (adc_sel_o == '0));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_powered_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (adc_pd_o && !busy_o));

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!done_o && adc_pd_o && (adc_sel_o == '0)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .NUM_CH   (NUM_CH),
  .WAKE_CYC (WAKE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .err_o       (err_o),
  .busy_o      (busy_o),
  .adc_pd_o    (adc_pd_o),
  .adc_sel_o   (adc_sel_o),
  .adc_valid_i (adc_valid_i)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  localparam int NCH = 2;
  localparam int DW  = 10;
  localparam int WK  = 12;
  localparam int TO  = 20;
  localparam int LAT = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [NCH-1:0]    ch_mask_i = '0;
  logic              busy_o, done_o, err_o, adc_pd_o;
  logic [NCH*DW-1:0] result_o;
  logic [NCH-1:0]    adc_sel_o;
  logic [DW-1:0]     adc_data_i;
  logic              adc_valid_i;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(
    .NUM_CH (NCH), .DATA_W (DW), .WAKE_CYC (WK), .TIMEOUT_CYC (TO)
  ) uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .ch_mask_i (ch_mask_i),
    .busy_o (busy_o), .done_o (done_o), .err_o (err_o), .result_o (result_o),
    .adc_pd_o (adc_pd_o), .adc_sel_o (adc_sel_o),
    .adc_data_i (adc_data_i), .adc_valid_i (adc_valid_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_data(input int tag, input int ch);
    return DW'((tag * 53 + ch * 211 + 7) % 1024);
  endfunction

  // Behavioural converter: answers LAT cycles after a select edge, holds
  // valid until the select bus is cleared.
  int             sess_tag = 0;
  bit             mute = 1'b0;
  logic [NCH-1:0] m_prev_sel;
  int             m_cnt;
  int             m_ch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev_sel  <= '0;
      m_cnt       <= 0;
      m_ch        <= 0;
      adc_valid_i <= 1'b0;
      adc_data_i  <= '0;
    end else begin
      m_prev_sel <= adc_sel_o;
      if (adc_sel_o == '0) begin
        adc_valid_i <= 1'b0;
        m_cnt       <= 0;
      end else if (m_prev_sel == '0) begin
        m_cnt <= LAT;
        m_ch  <= adc_sel_o[1] ? 1 : 0;
      end else if (m_cnt == 1) begin
        m_cnt <= 0;
        if (!mute) begin
          adc_valid_i <= 1'b1;
          adc_data_i  <= model_data(sess_tag, m_ch);
        end
      end else if (m_cnt > 1) begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  // Scoreboard queues filled by the driver.
  int exp_order[$];
  int exp_res_ch[$];
  int exp_res_val[$];

  // Monitor state, sampled on the falling edge.
  logic [NCH-1:0] s_prev_sel = '0;
  logic           s_prev_valid = 1'b0;
  int             pd_low_cnt = 0;
  bit             first_sel = 1'b1;
  int             done_cnt = 0;
  int             sel_cycles = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_sel_o != '0) sel_cycles++;
      if (s_prev_sel == '0 && adc_sel_o != '0) begin
        int got;
        got = adc_sel_o[1] ? 1 : 0;
        chk($countones(adc_sel_o) == 1, "R3", "one-hot select", int'(adc_sel_o), 1);
        chk(!adc_pd_o, "R3", "powered while selecting", int'(adc_pd_o), 0);
        chk(!s_prev_valid, "R7", "valid low in the cycle before select", int'(s_prev_valid), 0);
        if (first_sel) begin
          chk(pd_low_cnt == WK, "R2", "wake cycles before first select", pd_low_cnt, WK);
          first_sel = 1'b0;
        end
        if (exp_order.size() == 0) begin
          chk(1'b0, "R6", "unexpected channel selected", got, -1);
        end else begin
          int e;
          e = exp_order.pop_front();
          chk(got == e, "R6", "channel order", got, e);
        end
      end
      if (s_prev_sel != '0 && adc_sel_o != '0)
        chk(adc_sel_o == s_prev_sel, "R7", "no direct channel hop", int'(adc_sel_o), int'(s_prev_sel));
      if (done_o) begin
        done_cnt++;
        chk(adc_pd_o, "R5", "power-down high with done", int'(adc_pd_o), 1);
        while (exp_res_ch.size() > 0) begin
          int c;
          int v;
          c = exp_res_ch.pop_front();
          v = exp_res_val.pop_front();
          chk(int'(result_o[c*DW +: DW]) == v, "R4", "captured result", int'(result_o[c*DW +: DW]), v);
        end
      end
      if (adc_pd_o) begin
        pd_low_cnt = 0;
        first_sel  = 1'b1;
      end else if (adc_sel_o == '0 && first_sel) begin
        pd_low_cnt++;
      end
      s_prev_sel   = adc_sel_o;
      s_prev_valid = adc_valid_i;
    end
  end

  task automatic pulse_start(input logic [NCH-1:0] m);
    @(negedge clk);
    start_i   = 1'b1;
    ch_mask_i = m;
    @(negedge clk);
    start_i   = 1'b0;
    ch_mask_i = '0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_session(input logic [NCH-1:0] m, input int tag);
    sess_tag = tag;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        exp_order.push_back(c);
        exp_res_ch.push_back(c);
        exp_res_val.push_back(int'(model_data(tag, c)));
      end
    end
  endtask

  task automatic run_session(input logic [NCH-1:0] m, input int tag, input string req);
    int d0;
    d0 = done_cnt;
    expect_session(m, tag);
    pulse_start(m);
    chk(busy_o, req, "busy after start", int'(busy_o), 1);
    wait_idle();
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R5", "one done pulse per session", done_cnt - d0, 1);
    chk(exp_order.size() == 0, "R6", "all requested channels converted", exp_order.size(), 0);
    chk(adc_pd_o && !err_o, "R5", "powered down without error", int'({adc_pd_o, err_o}), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d0;
    logic [DW-1:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_pd_o && adc_sel_o == '0, "R1", "reset power-down and select",
        int'({adc_pd_o, adc_sel_o}), 4);
    chk(!busy_o && !done_o && !err_o, "R1", "reset flags",
        int'({busy_o, done_o, err_o}), 0);

    run_session(2'b01, 1, "R6");
    run_session(2'b10, 2, "R6");
    run_session(2'b11, 3, "R7");
    run_session(2'b11, 4, "R4");

    // R10: empty mask ignored
    pulse_start(2'b00);
    repeat (3) @(negedge clk);
    chk(!busy_o && adc_pd_o, "R10", "empty mask stays idle", int'({busy_o, adc_pd_o}), 1);

    // R9: second start while busy ignored; channel 1 result must not change
    keep = result_o[DW +: DW];
    d0 = done_cnt;
    expect_session(2'b01, 5);
    pulse_start(2'b01);
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    ch_mask_i = 2'b11;
    @(negedge clk);
    start_i = 1'b0;
    ch_mask_i = '0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "single done despite second start", done_cnt - d0, 1);
    chk(!busy_o, "R9", "idle after ignored start", int'(busy_o), 0);
    chk(result_o[DW +: DW] == keep, "R9", "channel 1 untouched", int'(result_o[DW +: DW]), int'(keep));

    // R8: converter never answers
    mute = 1'b1;
    keep = result_o[DW-1:0];
    d0 = done_cnt;
    exp_order.push_back(0);
    sess_tag = 6;
    pulse_start(2'b01);
    sel_cycles = 0;
    wait_idle();
    @(negedge clk);
    chk(sel_cycles == TO, "R8", "select held for timeout window", sel_cycles, TO);
    chk(err_o, "R8", "error flag raised", int'(err_o), 1);
    chk(adc_pd_o && adc_sel_o == '0, "R8", "powered down after abort",
        int'({adc_pd_o, adc_sel_o}), 4);
    chk(done_cnt == d0, "R8", "no done on abort", done_cnt - d0, 0);
    chk(result_o[DW-1:0] == keep, "R8", "result kept on abort", int'(result_o[DW-1:0]), int'(keep));
    repeat (5) @(negedge clk);
    chk(err_o, "R8", "error flag sticky", int'(err_o), 1);

    mute = 1'b0;
    run_session(2'b10, 7, "R8");
    chk(!err_o, "R8", "error cleared by next start", int'(err_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule